// File: doc/BRIEF.md
# Power-Up Reset Sequencer

This block brings a chip out of power-on reset in a fixed order. It runs on the main oscillator clock and listens to the raw active-low power-on reset pin. The pin is first brought into the clock domain and then debounced. Once the debounced level shows the pin released, the block walks through four start-up phases in a fixed order, each with its own length. Phase 1 waits for the oscillator and checks that it is valid. Phase 2 loads the fuses. Phase 3 starts the flash charge pump. Phase 4 powers the flash bank.

Each phase drives its own enable strobe, which the matching start-up logic uses. A three-bit code reports where the sequence stands. When the fourth phase ends, the block raises a done flag and releases the CPU reset. The CPU then fetches its first instruction from a constant boot address of zero.

If the pin drops again at any point, the sequence is abandoned and the CPU is held in reset. A low pin is treated as reset asserted, which matches the default level the pin takes through its pulldown when undriven. If the oscillator is not yet valid when phase 1 expires, phase 1 runs again from its start.

Top module: `pwrup_seq`

## Requirements
- R1: The pin passes through a two-flop synchronizer and then a filter. The filter accepts a new level only after the synchronized level has differed from the filtered level for 8 consecutive clocks. A high pulse of 7 clocks from idle is ignored, and so is a low pulse of 5 clocks while done.
- R2: While the filtered reset is asserted (low), all of the following hold: `phase_code` is 0, `phase_en` is all zero, `seq_done` is 0 and `cpu_rst_n` is 0.
- R3: After the pin goes high ahead of a clock edge, `phase_code` becomes 1 after the 11th edge. This delay is 2 synchronizer stages, 8 filter clocks and 1 sequencer register.
- R4: The phases run in the order 1, 2, 3, 4. They last 1032, 1160, 688 and 617 clocks respectively, so code 5 (done) is reached 3497 clocks after phase 1 begins.
- R5: The phase codes are 0 for idle, 1 to 4 for the active phases and 5 for done. In phase code k, only `phase_en[k-1]` is high. In idle and done, no enable is high.
- R6: `seq_done` and `cpu_rst_n` are high only while the code is 5. Once there, they stay high for as long as the filtered reset stays released.
- R7: If `osc_ok` is low on the last clock of phase 1, phase 1 restarts for another full 1032 clocks instead of moving on to phase 2.
- R8: After the pin goes low, the block behaves as follows:
  - The sequence carries on unchanged for 10 edges.
  - After the 11th edge, the code is 0 and `cpu_rst_n` is low.
  - This holds from any phase, including done.
- R9: `boot_addr` is always 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Main oscillator clock |
| por_n_raw | input | 1 | Raw active-low power-on reset pin |
| osc_ok | input | 1 | Oscillator valid indication |
| phase_en | output | 4 | One enable per start-up phase, bit 0 for phase 1 |
| phase_code | output | 3 | Current phase: 0 idle, 1-4 active, 5 done |
| seq_done | output | 1 | High once all phases have finished |
| cpu_rst_n | output | 1 | Active-low CPU reset |
| boot_addr | output | 32 | First fetch address, constant zero |

## Verification
Every result is due a fixed number of edges after its stimulus:
- a pin edge shows on the phase code after exactly 11 clock edges;
- each phase boundary falls at a cumulative offset from the entry into phase 1, which the bench computes from the four lengths and the number of phase-1 restarts.

The bench drives inputs on falling edges and samples outputs on the next falling edge. It counts rising edges from the stimulus and, on every cycle of each run, compares the outputs with the value its offset arithmetic predicts. Aborts are checked the same way: the running sequence is predicted to continue for 10 edges and to be idle from the 11th.

// File: rtl/pwrup_seq.sv
module pwrup_seq #(
  parameter int FILT_LEN = 8,
  parameter int P1_LEN = 1032,
  parameter int P2_LEN = 1160,
  parameter int P3_LEN = 688,
  parameter int P4_LEN = 617,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = '0
) (
  input  logic              clk_osc,
  input  logic              por_n_raw,
  input  logic              osc_ok,
  output logic [3:0]        phase_en,
  output logic [2:0]        phase_code,
  output logic              seq_done,
  output logic              cpu_rst_n,
  output logic [ADDR_W-1:0] boot_addr
);
  localparam int M12 = (P1_LEN > P2_LEN) ? P1_LEN : P2_LEN;
  localparam int M34 = (P3_LEN > P4_LEN) ? P3_LEN : P4_LEN;
  localparam int MAXLEN = (M12 > M34) ? M12 : M34;
  localparam int CW = $clog2(MAXLEN + 1);
  localparam int FW = $clog2(FILT_LEN + 1);
  localparam logic [2:0] PH_IDLE = 3'd0;
  localparam logic [2:0] PH_ONE  = 3'd1;
  localparam logic [2:0] PH_LAST = 3'd4;
  localparam logic [2:0] PH_DONE = 3'd5;

  logic [1:0]    sync_q   = 2'b00;
  logic          por_filt = 1'b0;
  logic [FW-1:0] filt_cnt = '0;
  logic [2:0]    phase_q  = 3'd0;
  logic [CW-1:0] cyc_q    = '0;
  logic [CW-1:0] last_cyc;

  always_ff @(posedge clk_osc) sync_q <= {sync_q[0], por_n_raw};

  always_ff @(posedge clk_osc) begin
    if (sync_q[1] == por_filt) begin
      filt_cnt <= '0;
    end else if (filt_cnt == FW'(FILT_LEN - 1)) begin
      por_filt <= sync_q[1];
      filt_cnt <= '0;
    end else begin
      filt_cnt <= filt_cnt + 1'b1;
    end
  end

  always_comb begin
    case (phase_q)
      3'd1:    last_cyc = CW'(P1_LEN - 1);
      3'd2:    last_cyc = CW'(P2_LEN - 1);
      3'd3:    last_cyc = CW'(P3_LEN - 1);
      default: last_cyc = CW'(P4_LEN - 1);
    endcase
  end

  always_ff @(posedge clk_osc) begin
    if (!por_filt) begin
      phase_q <= PH_IDLE;
      cyc_q   <= '0;
    end else if (phase_q == PH_IDLE) begin
      phase_q <= PH_ONE;
      cyc_q   <= '0;
    end else if (phase_q >= PH_ONE && phase_q <= PH_LAST) begin
      if (cyc_q == last_cyc) begin
        cyc_q <= '0;
        if (!(phase_q == PH_ONE && !osc_ok)) phase_q <= phase_q + 3'd1;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end else if (phase_q != PH_DONE) begin
      phase_q <= PH_IDLE;
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_en
    assign phase_en[g] = (phase_q == 3'(g + 1));
  end

  assign phase_code = phase_q;
  assign seq_done   = (phase_q == PH_DONE);
  assign cpu_rst_n  = (phase_q == PH_DONE);
  assign boot_addr  = BOOT_ADDR;
endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk (
  input logic       clk,
  input logic       por_q,
  input logic       osc_ok,
  input logic [3:0] phase_en,
  input logic [2:0] phase_code,
  input logic       cpu_rst_n
);
  // R2
  idle_in_reset_chk: assert property (@(posedge clk)
    !por_q |=> (phase_code == 3'd0 && !cpu_rst_n));

  // R5
  one_enable_chk: assert property (@(posedge clk) $onehot0(phase_en));

  // R7
  osc_gate_chk: assert property (@(posedge clk) disable iff (!por_q)
    $rose(phase_en[1]) |-> $past(osc_ok));

  // R6
  cpu_release_chk: assert property (@(posedge clk) disable iff (!por_q)
    $rose(cpu_rst_n) |-> $past(phase_code) == 3'd4);

  // R4
  phase_order_chk: assert property (@(posedge clk) disable iff (!por_q)
    (phase_code != $past(phase_code)) |-> phase_code == 3'($past(phase_code) + 3'd1));
endmodule

bind pwrup_seq pwrup_seq_chk u_chk (
  .clk(clk_osc), .por_q(por_filt), .osc_ok(osc_ok),
  .phase_en(phase_en), .phase_code(phase_code), .cpu_rst_n(cpu_rst_n)
);

// File: tb/test_pwrup_seq.sv
`timescale 1ns/1ps
module test_pwrup_seq;
  localparam int P1 = 1032, P2 = 1160, P3 = 688, P4 = 617;
  localparam int TOTAL = P1 + P2 + P3 + P4;
  localparam int DLY = 11;

  logic clk = 1'b0;
  logic por_n_raw = 1'b0;
  logic osc_ok = 1'b0;
  logic [3:0] phase_en;
  logic [2:0] phase_code;
  logic seq_done, cpu_rst_n;
  logic [31:0] boot_addr;
  int errs = 0;
  int checks = 0;

  always #2 clk = ~clk;

  pwrup_seq i_pwrup_seq (
    .clk_osc(clk), .por_n_raw(por_n_raw), .osc_ok(osc_ok),
    .phase_en(phase_en), .phase_code(phase_code), .seq_done(seq_done),
    .cpu_rst_n(cpu_rst_n), .boot_addr(boot_addr)
  );

  function automatic int exp_code(int t, int reps);
    int r = t - P1 * (reps + 1);
    if (r < 0) return 1;
    if (r < P2) return 2;
    r -= P2;
    if (r < P3) return 3;
    r -= P3;
    if (r < P4) return 4;
    return 5;
  endfunction

  task automatic check_out(int code, string tag);
    logic [3:0] en_e = (code >= 1 && code <= 4) ? 4'(1 << (code - 1)) : 4'd0;
    logic ok = (phase_code == 3'(code)) && (phase_en == en_e) &&
               (seq_done == (code == 5)) && (cpu_rst_n == (code == 5)) &&
               (boot_addr == 32'h0);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: code=%0d en=%b done=%b rst_n=%b addr=%h expected code=%0d en=%b done=%b rst_n=%b addr=0",
               tag, phase_code, phase_en, seq_done, cpu_rst_n, boot_addr,
               code, en_e, code == 5, code == 5);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // release the pin and follow the sequence up to offset stop_t after phase 1 entry
  task automatic run_release(int reps, int stop_t);
    @(negedge clk);
    osc_ok = (reps == 0);
    por_n_raw = 1'b1;
    for (int j = 1; j <= DLY + stop_t; j++) begin
      tick();
      if (j < DLY) check_out(0, "R3 start delay");
      else begin
        check_out(exp_code(j - DLY, reps), "R4/R5/R6/R7 phase timing");
        if (j - DLY == P1 * reps) osc_ok = 1'b1;
      end
    end
  endtask

  task automatic abort_at(int t0, int reps);
    por_n_raw = 1'b0;
    for (int j = 1; j <= 20; j++) begin
      tick();
      if (j < DLY) check_out(exp_code(t0 + j, reps), "R8 pre-abort");
      else check_out(0, "R8/R2 aborted");
    end
  endtask

  initial begin
    #800000;
    errs++;
    checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    // R2 R9: reset state
    for (int i = 0; i < 30; i++) begin tick(); check_out(0, "R2/R9 reset"); end

    // R1: 7-clock high glitch ignored
    por_n_raw = 1'b1;
    for (int i = 0; i < 7; i++) tick();
    por_n_raw = 1'b0;
    for (int i = 0; i < 30; i++) begin tick(); check_out(0, "R1 short glitch"); end

    // R1 R8: 8-clock pulse accepted, then dropped
    por_n_raw = 1'b1;
    for (int j = 1; j <= 40; j++) begin
      tick();
      if (j == 8) por_n_raw = 1'b0;
      if (j >= 11 && j <= 18) check_out(1, "R1 accepted pulse");
      else check_out(0, "R1/R8 pulse idle");
    end

    // R4 R6: full run, hold done through a short low glitch, then abort
    run_release(0, TOTAL + 10);
    por_n_raw = 1'b0;
    for (int i = 0; i < 5; i++) begin tick(); check_out(5, "R1/R6 done glitch"); end
    por_n_raw = 1'b1;
    for (int i = 0; i < 40; i++) begin tick(); check_out(5, "R6 done hold"); end
    abort_at(TOTAL + 100, 0);

    // R8: abort in phase 2
    run_release(0, 1500);
    abort_at(1500, 0);

    // R7: two phase-1 restarts
    run_release(2, TOTAL + 2 * P1 + 5);
    abort_at(TOTAL + 2 * P1 + 5, 2);

    // R8: abort in phase 3
    run_release(0, P1 + P2 + 100);
    abort_at(P1 + P2 + 100, 0);

    // R8: abort in last cycles of phase 4
    run_release(0, TOTAL - 12);
    abort_at(TOTAL - 12, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule